// File: doc/BRIEF.md
# Port-Size Bus Transfer Splitter

This block sits between a host that issues byte, word, longword or 16-byte line accesses and an external data port that is 8, 16 or 32 bits wide. It takes one host request and plays it out on the external side as the number of port-sized beats that the access needs. Each beat carries the right address, write data on the right byte lanes and the right byte strobes, and read bytes are collected into one host-sized result.

Reads and writes have separate burst enables. With the enable for the direction set, a multi-beat access uses a single address phase followed by back-to-back data beats. With it clear, every beat is a separate transfer with its own address phase. A strobe-mode bit selects whether byte strobes are driven on reads as well as on writes. The host holds `req_i` until it sees the one-cycle `ack_o`. The external device acknowledges each beat with `ext_ack_i`.

Top module: `port_split_xfer`

## Requirements
- R1: After reset, `ack_o`, `ext_ts_o`, `ext_dphase_o` and `ext_burst_o` are low and `ext_be_o` is zero.
- R2: The access size is `size_i` (0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 16 bytes). The port width is `port_i` (0 = 8 bit, 1 = 16 bit, 2 or 3 = 32 bit). An access that is no wider than the port takes exactly one beat. A wider access takes exactly size/port-width beats.
- R3: Without bursting, every beat begins with a one-cycle `ext_ts_o` address phase, is followed by a data phase (`ext_dphase_o`), and ends with its own `ext_ack_i`. The beat address advances by the port width in bytes from `addr_i`, which is aligned to the access size.
- R4: A multi-beat access bursts when its direction's enable is set: `ctl_i[0]` for reads, `ctl_i[1]` for writes. A burst has one `ext_ts_o` and then consecutive data beats with no further address phase. `ext_burst_o` is high throughout the burst. `ext_addr_o` still tracks the address of the current beat.
- R5: Lane k is `ext_wdata_o`/`ext_rdata_i` bits [8k+7:8k]. The byte at address a travels on lane 3 − (a mod port bytes). Host data is right-aligned and big-endian: the byte at the lowest address is the most significant byte of the access.
- R6: `ext_be_o` marks exactly the lanes that carry bytes of the current beat. It is driven on writes always. On reads it is driven only when `ctl_i[2]` is 1, and is zero otherwise.
- R7: On a read, `rdata_o` holds the assembled big-endian result with all bits above the access size zero, valid while `ack_o` is high. The first beat fills the most significant bytes.
- R8: `ack_o` is a one-cycle pulse. It is asserted in the cycle after the last beat's `ext_ack_i` and never earlier.
- R9: `ctl_i[5:3]` are reserved and have no effect on any output.
- R10: While a data phase waits for `ext_ack_i`, `ext_addr_o`, `ext_be_o` and `ext_wdata_o` stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Host request, held until `ack_o` |
| we_i | input | 1 | 1 = write, 0 = read |
| size_i | input | 2 | Access size code |
| addr_i | input | ADDR_W | Access start address, size-aligned |
| wdata_i | input | 128 | Right-aligned big-endian write data |
| port_i | input | 2 | External port width code |
| ctl_i | input | 6 | [0] read burst, [1] write burst, [2] strobes on reads, [5:3] reserved |
| ack_o | output | 1 | Host completion pulse |
| rdata_o | output | 128 | Assembled read data |
| ext_addr_o | output | ADDR_W | Current beat address |
| ext_ts_o | output | 1 | Address phase strobe |
| ext_dphase_o | output | 1 | Data phase active |
| ext_burst_o | output | 1 | Transfer is a burst |
| ext_we_o | output | 1 | External write |
| ext_wdata_o | output | 32 | Lane-steered write data |
| ext_be_o | output | 4 | Byte strobes per lane |
| ext_rdata_i | input | 32 | External read data |
| ext_ack_i | input | 1 | Beat acknowledge |

## Verification
The assertions assume that the external side raises `ext_ack_i` only during a data phase. They also assume that the host keeps `req_i` and its fields steady until `ack_o` and presents an address aligned to the access size. The bench's responder acknowledges only while `ext_dphase_o` is high, after zero to two wait cycles, and drops `ext_ack_i` at every other time. The host task drives only aligned addresses and releases the request in the cycle it sees `ack_o`. Unused read lanes carry a filler byte, so a design that picks the wrong lane shows up in the assembled result.

// File: rtl/psx_pkg.sv
package psx_pkg;
  localparam int LANES      = 4;
  localparam int PORT_W     = 8 * LANES;
  localparam int HOST_BYTES = 16;
  localparam int HOST_W     = 8 * HOST_BYTES;
  localparam int CNT_W      = $clog2(HOST_BYTES);

  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_DATA, ST_DONE} state_e;

  function automatic logic [2:0] size_log2(logic [1:0] sz);
    case (sz)
      2'd0:    return 3'd0;
      2'd1:    return 3'd1;
      2'd2:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [1:0] port_log2(logic [1:0] p);
    case (p)
      2'd0:    return 2'd0;
      2'd1:    return 2'd1;
      default: return 2'd2;
    endcase
  endfunction
endpackage

// File: rtl/psx_beat_plan.sv
module psx_beat_plan
  import psx_pkg::*;
(
  input  logic [1:0]       size_i,
  input  logic [1:0]       port_i,
  input  logic             we_i,
  input  logic             rd_burst_en_i,
  input  logic             wr_burst_en_i,
  output logic [2:0]       size_lg_o,
  output logic [1:0]       port_lg_o,
  output logic [1:0]       bpb_lg_o,
  output logic [CNT_W-1:0] beats_m1_o,
  output logic             burst_o
);
  logic [CNT_W:0] span;

  always_comb begin
    size_lg_o = size_log2(size_i);
    port_lg_o = port_log2(port_i);
    // bytes per beat = min(access bytes, port bytes)
    bpb_lg_o  = (size_lg_o < {1'b0, port_lg_o}) ? size_lg_o[1:0] : port_lg_o;
    span       = (CNT_W+1)'(1) << (size_lg_o - {1'b0, bpb_lg_o});
    beats_m1_o = CNT_W'(span - 1'b1);
    burst_o    = (beats_m1_o != '0) && (we_i ? wr_burst_en_i : rd_burst_en_i);
  end
endmodule

// File: rtl/psx_wr_steer.sv
module psx_wr_steer
  import psx_pkg::*;
(
  input  logic [HOST_W-1:0] wdata_i,
  input  logic              we_i,
  input  logic              strobe_en_i,
  input  logic [2:0]        size_lg_i,
  input  logic [1:0]        port_lg_i,
  input  logic [1:0]        bpb_lg_i,
  input  logic [1:0]        addr_lo_i,
  input  logic [CNT_W-1:0]  beat_i,
  output logic [PORT_W-1:0] lane_data_o,
  output logic [LANES-1:0]  lane_be_o
);
  always_comb begin
    int j;
    int ofs;
    logic [1:0] lane;
    logic [3:0] pos;
    lane_data_o = '0;
    lane_be_o   = '0;
    for (int k = 0; k < LANES; k++) begin
      j    = (int'(beat_i) << bpb_lg_i) + k;
      ofs  = (int'(addr_lo_i) + k) & ((1 << port_lg_i) - 1);
      lane = 2'(LANES - 1 - ofs);
      pos  = 4'((1 << size_lg_i) - 1 - j);
      if (k < (1 << bpb_lg_i)) begin
        if (we_i) lane_data_o[lane*8 +: 8] = wdata_i[pos*8 +: 8];
        if (strobe_en_i) lane_be_o[lane] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/psx_rd_pack.sv
module psx_rd_pack
  import psx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              cap_i,
  input  logic [PORT_W-1:0] lane_data_i,
  input  logic [2:0]        size_lg_i,
  input  logic [1:0]        port_lg_i,
  input  logic [1:0]        bpb_lg_i,
  input  logic [1:0]        addr_lo_i,
  input  logic [CNT_W-1:0]  beat_i,
  output logic [HOST_W-1:0] rdata_o
);
  logic [HOST_W-1:0] buf_q, buf_d;

  always_comb begin
    int j;
    int ofs;
    logic [1:0] lane;
    logic [3:0] pos;
    buf_d = clear_i ? '0 : buf_q;
    for (int k = 0; k < LANES; k++) begin
      j    = (int'(beat_i) << bpb_lg_i) + k;
      ofs  = (int'(addr_lo_i) + k) & ((1 << port_lg_i) - 1);
      lane = 2'(LANES - 1 - ofs);
      pos  = 4'((1 << size_lg_i) - 1 - j);
      if (cap_i && (k < (1 << bpb_lg_i))) buf_d[pos*8 +: 8] = lane_data_i[lane*8 +: 8];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) buf_q <= '0;
    else         buf_q <= buf_d;
  end

  assign rdata_o = buf_q;
endmodule

// File: rtl/port_split_xfer.sv
module port_split_xfer
  import psx_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [1:0]        size_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [HOST_W-1:0] wdata_i,
  input  logic [1:0]        port_i,
  input  logic [5:0]        ctl_i,
  output logic              ack_o,
  output logic [HOST_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] ext_addr_o,
  output logic              ext_ts_o,
  output logic              ext_dphase_o,
  output logic              ext_burst_o,
  output logic              ext_we_o,
  output logic [PORT_W-1:0] ext_wdata_o,
  output logic [LANES-1:0]  ext_be_o,
  input  logic [PORT_W-1:0] ext_rdata_i,
  input  logic              ext_ack_i
);
  state_e            state_q;
  logic              we_q, rdb_q, wrb_q, bem_q;
  logic [1:0]        size_q, port_q;
  logic [ADDR_W-1:0] addr_q;
  logic [HOST_W-1:0] wdata_q;
  logic [CNT_W-1:0]  beat_q;

  logic [2:0]        size_lg;
  logic [1:0]        port_lg, bpb_lg;
  logic [CNT_W-1:0]  beats_m1;
  logic              burst, last, active;
  logic [ADDR_W-1:0] beat_addr;
  logic [PORT_W-1:0] lane_data;
  logic [LANES-1:0]  lane_be;

  // reserved control bits are deliberately dropped
  logic unused_ctl;
  assign unused_ctl = ^ctl_i[5:3];

  psx_beat_plan u_plan (
    .size_i        (size_q),
    .port_i        (port_q),
    .we_i          (we_q),
    .rd_burst_en_i (rdb_q),
    .wr_burst_en_i (wrb_q),
    .size_lg_o     (size_lg),
    .port_lg_o     (port_lg),
    .bpb_lg_o      (bpb_lg),
    .beats_m1_o    (beats_m1),
    .burst_o       (burst)
  );

  assign beat_addr = addr_q + (ADDR_W'(beat_q) << bpb_lg);
  assign last      = (beat_q == beats_m1);
  assign active    = (state_q == ST_ADDR) || (state_q == ST_DATA);

  psx_wr_steer u_steer (
    .wdata_i     (wdata_q),
    .we_i        (we_q),
    .strobe_en_i (we_q | bem_q),
    .size_lg_i   (size_lg),
    .port_lg_i   (port_lg),
    .bpb_lg_i    (bpb_lg),
    .addr_lo_i   (beat_addr[1:0]),
    .beat_i      (beat_q),
    .lane_data_o (lane_data),
    .lane_be_o   (lane_be)
  );

  psx_rd_pack u_pack (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     ((state_q == ST_IDLE) && req_i),
    .cap_i       ((state_q == ST_DATA) && ext_ack_i && !we_q),
    .lane_data_i (ext_rdata_i),
    .size_lg_i   (size_lg),
    .port_lg_i   (port_lg),
    .bpb_lg_i    (bpb_lg),
    .addr_lo_i   (beat_addr[1:0]),
    .beat_i      (beat_q),
    .rdata_o     (rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      we_q    <= 1'b0;
      rdb_q   <= 1'b0;
      wrb_q   <= 1'b0;
      bem_q   <= 1'b0;
      size_q  <= '0;
      port_q  <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      beat_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (req_i) begin
          we_q    <= we_i;
          size_q  <= size_i;
          port_q  <= port_i;
          rdb_q   <= ctl_i[0];
          wrb_q   <= ctl_i[1];
          bem_q   <= ctl_i[2];
          addr_q  <= addr_i;
          wdata_q <= wdata_i;
          beat_q  <= '0;
          state_q <= ST_ADDR;
        end
        ST_ADDR: state_q <= ST_DATA;
        ST_DATA: if (ext_ack_i) begin
          if (last) state_q <= ST_DONE;
          else begin
            beat_q  <= beat_q + 1'b1;
            state_q <= burst ? ST_DATA : ST_ADDR;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ack_o        = (state_q == ST_DONE);
  assign ext_ts_o     = (state_q == ST_ADDR);
  assign ext_dphase_o = (state_q == ST_DATA);
  assign ext_burst_o  = active && burst;
  assign ext_we_o     = active && we_q;
  assign ext_addr_o   = beat_addr;
  assign ext_wdata_o  = active ? lane_data : '0;
  assign ext_be_o     = active ? lane_be : '0;

  AST_TS_THEN_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_ts_o |=> (ext_dphase_o && !ext_ts_o)) else $error("ts not followed by data"); // R3
  AST_ACK_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o) else $error("host ack longer than one cycle"); // R8
  AST_ACK_AFTER_BEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> $past(ext_ack_i && ext_dphase_o)) else $error("host ack without beat ack"); // R8
  AST_BURST_NO_READDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_dphase_o && ext_burst_o && ext_ack_i && !last) |=> (ext_dphase_o && !ext_ts_o))
    else $error("burst re-issued an address phase"); // R4
  AST_RD_STROBE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_dphase_o && !ext_we_o && !bem_q) |-> (ext_be_o == '0)) else $error("read strobes driven"); // R6
  AST_WR_STROBE_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_dphase_o && ext_we_o) |-> (ext_be_o != '0)) else $error("write without strobes"); // R6
  AST_WAIT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_dphase_o && !ext_ack_i) |=> ($stable(ext_addr_o) && $stable(ext_be_o) && $stable(ext_wdata_o)))
    else $error("beat changed while waiting"); // R10
endmodule

// File: tb/port_split_xfer_tb.sv
module port_split_xfer_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req = 1'b0, we = 1'b0;
  logic [1:0]   size = '0, port = '0;
  logic [31:0]  addr = '0;
  logic [127:0] wdata = '0;
  logic [5:0]   ctl = '0;
  logic         ack;
  logic [127:0] rdata;
  logic [31:0]  x_addr;
  logic         x_ts, x_dph, x_burst, x_we;
  logic [31:0]  x_wdata;
  logic [3:0]   x_be;
  logic [31:0]  x_rdata = '0;
  logic         x_ack = 1'b0;

  int total = 0, bad = 0, cyc = 0;

  always #4 clk = ~clk;

  port_split_xfer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .size_i(size),
    .addr_i(addr), .wdata_i(wdata), .port_i(port), .ctl_i(ctl),
    .ack_o(ack), .rdata_o(rdata), .ext_addr_o(x_addr), .ext_ts_o(x_ts),
    .ext_dphase_o(x_dph), .ext_burst_o(x_burst), .ext_we_o(x_we),
    .ext_wdata_o(x_wdata), .ext_be_o(x_be), .ext_rdata_i(x_rdata), .ext_ack_i(x_ack)
  );

  task automatic chk(bit ok, string tag, string what, logic [127:0] act, logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] mem_byte(logic [31:0] a);
    return 8'(a * 7) ^ 8'hA5;
  endfunction

  function automatic logic [31:0] mem_resp(logic [31:0] a, int pb);
    logic [31:0] r;
    logic [31:0] base;
    base = a & ~(32'(pb) - 32'd1);
    for (int l = 0; l < 4; l++) begin
      if (3 - l < pb) r[l*8 +: 8] = mem_byte(base + 32'(3 - l));
      else            r[l*8 +: 8] = 8'hEE;
    end
    return r;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic run(bit w, int sz, logic [31:0] a, logic [127:0] wd, int pt, logic [5:0] c,
                     output logic [127:0] got);
    int s, p, bpb, n, beat, wt, guard;
    bit bst, started, ts_seen, done, exp_ts;
    logic [31:0]  e_addr[16];
    logic [31:0]  e_wd[16];
    logic [3:0]   e_be[16];
    logic [127:0] e_rd;
    logic [31:0]  h_addr;
    logic [3:0]   h_be;
    s   = (sz == 3) ? 16 : (1 << sz);
    p   = (pt == 0) ? 1 : (pt == 1) ? 2 : 4;
    bpb = (s < p) ? s : p;
    n   = s / bpb;
    bst = (n > 1) && (w ? c[1] : c[0]);
    e_rd = '0;
    for (int j = 0; j < s; j++) e_rd[(s-1-j)*8 +: 8] = mem_byte(a + 32'(j));
    for (int i = 0; i < n; i++) begin
      e_addr[i] = a + 32'(i * bpb);
      e_wd[i] = '0;
      e_be[i] = '0;
      for (int k = 0; k < bpb; k++) begin
        int j, ln;
        j  = i * bpb + k;
        ln = 3 - ((int'(a[3:0]) + j) % p);
        if (w) e_wd[i][ln*8 +: 8] = wd[(s-1-j)*8 +: 8];
        if (w || c[2]) e_be[i][ln] = 1'b1;
      end
    end
    @(negedge clk);
    req = 1'b1; we = w; size = 2'(sz); addr = a; wdata = wd; port = 2'(pt); ctl = c;
    beat = 0; started = 0; ts_seen = 0; done = 0; guard = 0; wt = 0;
    h_addr = '0; h_be = '0; got = '0;
    while (!done && guard < 400) begin
      @(negedge clk);
      guard++;
      chk(ack == (beat == n), "R8", "host ack timing", 128'(ack), 128'(beat == n));
      if (ack) begin
        done = 1;
        got  = rdata;
        if (!w) chk(rdata == e_rd, "R7", "assembled read data", rdata, e_rd);
        req = 1'b0; x_ack = 1'b0;
      end else begin
        if (x_ts) begin
          ts_seen = 1;
          chk(beat < n, "R2", "address phase past last beat", 128'(beat), 128'(n));
          if (beat < n) chk(x_addr == e_addr[beat], "R3", "address at ts", 128'(x_addr), 128'(e_addr[beat]));
          chk(x_burst == bst, "R4", "burst flag at ts", 128'(x_burst), 128'(bst));
          chk(x_we == w, "R3", "direction at ts", 128'(x_we), 128'(w));
        end
        if (x_dph) begin
          if (beat >= n) begin
            chk(0, "R2", "extra data beat", 128'(beat), 128'(n));
            x_ack = 1'b0;
          end else begin
            if (!started) begin
              started = 1;
              exp_ts  = (beat == 0) || !bst;
              chk(ts_seen == exp_ts, bst ? "R4" : "R3", "address phase before beat",
                  128'(ts_seen), 128'(exp_ts));
              ts_seen = 0;
              chk(x_addr == e_addr[beat], "R3", "beat address", 128'(x_addr), 128'(e_addr[beat]));
              chk(x_be == e_be[beat], "R6", "byte strobes", 128'(x_be), 128'(e_be[beat]));
              if (w) chk(x_wdata == e_wd[beat], "R5", "write lanes", 128'(x_wdata), 128'(e_wd[beat]));
              chk(x_burst == bst, "R4", "burst flag in beat", 128'(x_burst), 128'(bst));
              h_addr = x_addr; h_be = x_be;
              wt = $urandom % 3;
            end else begin
              chk(x_addr == h_addr && x_be == h_be, "R10", "beat held during wait",
                  {x_addr, x_be}, {h_addr, h_be});
            end
            if (wt == 0) begin
              x_ack = 1'b1;
              x_rdata = mem_resp(x_addr, p);
              beat++;
              started = 0;
            end else begin
              wt--;
              x_ack = 1'b0;
            end
          end
        end else begin
          x_ack = 1'b0;
        end
      end
    end
    if (!done) chk(0, "R8", "host ack never came", 128'(beat), 128'(n));
  endtask

  initial begin
    logic [127:0] g1, g2;
    logic [5:0] ctls[4];
    ctls[0] = 6'b000_000; ctls[1] = 6'b000_111; ctls[2] = 6'b000_001; ctls[3] = 6'b000_010;
    repeat (3) @(negedge clk);
    chk(!ack && !x_ts && !x_dph && !x_burst && x_be == '0, "R1", "reset outputs",
        {ack, x_ts, x_dph, x_burst, x_be}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!ack && !x_ts && !x_dph && x_be == '0, "R1", "idle after reset",
        {ack, x_ts, x_dph, x_be}, '0);
    for (int pt = 0; pt < 4; pt++)
      for (int sz = 0; sz < 4; sz++)
        for (int ci = 0; ci < 4; ci++)
          for (int w = 0; w < 2; w++) begin
            int it;
            logic [31:0] a;
            logic [127:0] wd;
            it = ((pt * 4 + sz) * 4 + ci) * 2 + w;
            a  = 32'h1000 + 32'(it * 32);
            case (sz)
              0: a = a + 32'(it % 4);
              1: a = a + 32'((it % 2) * 2);
              2: a = a + 32'((it % 4) * 4);
              default: ;
            endcase
            wd = {$urandom, $urandom, $urandom, $urandom};
            run(w[0], sz, a, wd, pt, ctls[ci], g1);
          end
    // R9: reserved control bits must not change anything
    run(1'b0, 2, 32'h2004, '0, 0, 6'b000_001, g1);
    run(1'b0, 2, 32'h2004, '0, 0, 6'b111_001, g2);
    chk(g1 == g2, "R9", "reserved bits altered read", g2, g1);
    run(1'b1, 3, 32'h2100, {4{32'hC0DE_F00D}}, 1, 6'b101_010, g2);
    run(1'b0, 0, 32'h2203, '0, 2, 6'b010_000, g2);
    chk(g2 == 128'(mem_byte(32'h2203)), "R9", "byte read with reserved bits", g2,
        128'(mem_byte(32'h2203)));
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule